// File: doc/BRIEF.md
# Write-Only Serial Configuration Receiver

This block is the slave side of a two-wire configuration link whose data only ever flows into the device. It oversamples the serial clock and data lines with the system clock and finds start and stop conditions. It then takes a rigid eleven-byte write frame: a device address, two placeholder header bytes whose values are discarded, and eight data bytes. The data bytes land in eight 8-bit configuration registers. Those registers come out of reset holding usable defaults, so the host does not have to send any frame for the part to work.

The registers drive the controls of a clock generator. Register 1 holds a run/hold-low bit for each clock output. Register 0 holds a frequency select, a spread enable and a bit that places every output in high impedance. A bit is sampled on each rising serial clock edge. The receiver answers each accepted byte by pulling the data line low during the ninth clock slot.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset, `cfg_regs` equals the default image: register 1 = 8'hFF and every other register = 8'h00. With that image, `clk_run` is all ones, `clk_oe` is all ones, `freq_sel` is 0 and `spread_en` is 0.
- R2: The first byte after a start must equal 8'hD2. Any other value gives no acknowledge in that byte's ninth slot, and no register changes until the next start.
- R3: After a matching address, `ack_drive` is high during the ninth serial clock slot of the address byte and of every later byte. A host sampling the data line while the serial clock is high in that slot therefore reads 0.
- R4: The two bytes that follow the address are consumed, and their values have no effect. Data byte k (k = 0..7) is stored in register k, which appears at `cfg_regs[8k+7:8k]`. Bits are taken most significant first on rising serial clock edges.
- R5: Bytes that arrive after data byte 7 and before a stop are acknowledged and do not change any register.
- R6: A start condition resets the framing. Here a start is the data line falling while the serial clock is high. This holds even inside an unfinished frame or in the middle of a byte, and the next byte is then treated as an address.
- R7: Each data byte is committed when its eighth bit arrives. A frame that is cut short by a stop keeps the bytes already committed and leaves the remaining registers unchanged. Here a stop is the data line rising while the serial clock is high.
- R8: `clk_run[i]` follows register 1 bit i: 1 lets clock i run and 0 holds it low. Register 0 bit 5 set drives all of `clk_oe` to 0. `freq_sel` is register 0 bits 3:0, and `spread_en` is register 0 bit 4.
- R9: The reserved bits, register 0 bits 7:6, are stored exactly as written and can be observed on `cfg_regs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line, as seen on the wire |
| ack_drive | output | 1 | 1 = pull the data line low |
| cfg_regs | output | 64 | Eight configuration registers, register k at bits 8k+7:8k |
| clk_run | output | 8 | Per-output run enable (0 = held low) |
| clk_oe | output | 8 | Per-output drive enable (0 = high impedance) |
| freq_sel | output | 4 | Frequency selection code |
| spread_en | output | 1 | Spread-spectrum enable |

## Verification
The hardest case to reach from the ports is a repeated start that lands partway through a byte of a frame that has already committed some data. This is the only case that shows the byte counter restarted, rather than continuing to the next register. The stimulus commits two data bytes and sends four bits of a third. It then issues a start and a short second frame. That frame must overwrite register 0, leave register 1 intact and leave register 2 untouched. Misaddressed frames are swept over every single-bit corruption of the address, so each bit of the comparison is exercised.

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx #(
  parameter int              NREG        = 8,
  parameter int              HDR         = 2,
  parameter int              NCLK        = 8,
  parameter logic [7:0]      DEV_ADDR    = 8'hD2,
  parameter logic [NREG*8-1:0] DEFAULT_CFG = 'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              ack_drive,
  output logic [NREG*8-1:0] cfg_regs,
  output logic [NCLK-1:0]   clk_run,
  output logic [NCLK-1:0]   clk_oe,
  output logic [3:0]        freq_sel,
  output logic              spread_en
);
  localparam int DAT0  = 1 + HDR;
  localparam int FRAME = DAT0 + NREG;
  localparam int BCW   = $clog2(FRAME + 1);

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic       active;
  logic [3:0] bitcnt;
  logic [BCW-1:0] bytecnt;
  logic [7:0] shift;
  logic [7:0] regs_q [NREG];

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start    = scl_s & scl_d & sda_d & ~sda_s;
  wire stop     = scl_s & scl_d & ~sda_d & sda_s;
  wire [7:0] nxt = {shift[6:0], sda_s};
  wire byte_done = active & scl_rise & (bitcnt == 4'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      bitcnt    <= '0;
      bytecnt   <= '0;
      shift     <= '0;
      ack_drive <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      bitcnt    <= '0;
      bytecnt   <= '0;
      ack_drive <= 1'b0;
    end else if (stop) begin
      active    <= 1'b0;
      bitcnt    <= '0;
      bytecnt   <= '0;
      ack_drive <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (bitcnt == 4'd8) begin
          bitcnt <= '0;
          if (bytecnt != BCW'(FRAME)) bytecnt <= bytecnt + 1'b1;
        end else begin
          shift  <= nxt;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 4'd7 && bytecnt == '0 && nxt != DEV_ADDR) active <= 1'b0;
        end
      end
      if (scl_fall) ack_drive <= (bitcnt == 4'd8);
    end else begin
      ack_drive <= 1'b0;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[g] <= DEFAULT_CFG[8*g +: 8];
      else if (byte_done && bytecnt == BCW'(DAT0 + g))
        regs_q[g] <= nxt;
    end
    assign cfg_regs[8*g +: 8] = regs_q[g];
  end

  assign clk_run   = regs_q[1][NCLK-1:0];
  assign clk_oe    = {NCLK{~regs_q[0][5]}};
  assign freq_sel  = regs_q[0][3:0];
  assign spread_en = regs_q[0][4];

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(cfg_regs));

  // R4
  write_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_rise |=> $stable(cfg_regs));

  // R3
  ack_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drive) |-> !scl_s);

  // R3
  ack_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_d && !start && !stop) |=> $stable(ack_drive) || !scl_s);

  // R5
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bytecnt <= BCW'(FRAME)) && (bitcnt <= 4'd8));
endmodule

// File: tb/sim_cfg_serial_rx.sv
module sim_cfg_serial_rx;
  localparam int Q = 10;
  localparam logic [7:0] ADDR = 8'hD2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic ack_drive;
  logic [63:0] cfg_regs;
  logic [7:0] clk_run, clk_oe;
  logic [3:0] freq_sel;
  logic spread_en;
  wire sda_line = sda_h & ~ack_drive;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [63:0] exp_cfg;

  always #10 clk = ~clk;

  cfg_serial_rx u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_line),
    .ack_drive(ack_drive), .cfg_regs(cfg_regs), .clk_run(clk_run),
    .clk_oe(clk_oe), .freq_sel(freq_sel), .spread_en(spread_en));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic s_start();
    sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); sda_h = 1'b0; wq(); scl_h = 1'b0; wq();
  endtask

  task automatic s_stop();
    sda_h = 1'b0; wq(); scl_h = 1'b1; wq(); sda_h = 1'b1; wq(); wq();
  endtask

  task automatic s_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_h = b[i]; wq(); scl_h = 1'b1; wq(); scl_h = 1'b0; wq();
    end
  endtask

  task automatic s_byte(input logic [7:0] b, output bit acked);
    s_bits(b, 8);
    sda_h = 1'b1; wq(); scl_h = 1'b1;
    repeat (Q/2) @(negedge clk);
    acked = (sda_line == 1'b0);
    repeat (Q/2) @(negedge clk);
    scl_h = 1'b0; wq();
  endtask

  // Sends address, two header bytes and ndat data bytes; returns ack count.
  task automatic s_frame(input logic [7:0] a, input logic [7:0] c0, input logic [7:0] c1,
                         input logic [95:0] dat, input int ndat, input bit do_stop,
                         output int acks);
    bit ak;
    acks = 0;
    s_start();
    s_byte(a, ak);  acks += ak;
    s_byte(c0, ak); acks += ak;
    s_byte(c1, ak); acks += ak;
    for (int k = 0; k < ndat; k++) begin
      s_byte(dat[8*k +: 8], ak); acks += ak;
    end
    if (do_stop) s_stop();
  endtask

  task automatic chk_ctl(input string req);
    chk(req, {56'd0, clk_run}, {56'd0, exp_cfg[15:8]});
    chk(req, {56'd0, clk_oe}, {56'd0, {8{~exp_cfg[5]}}});
    chk(req, {60'd0, freq_sel}, {60'd0, exp_cfg[3:0]});
    chk(req, {63'd0, spread_en}, {63'd0, exp_cfg[4]});
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int acks;
    logic [95:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset image
    exp_cfg = 64'h0000_0000_0000_FF00;
    chk("R1 reset cfg", cfg_regs, exp_cfg);
    chk("R1 reset ack", {63'd0, ack_drive}, 64'd0);
    chk_ctl("R1/R8 reset controls");

    // R4 R8 R9 sweep of data patterns with varying header bytes
    for (int f = 0; f < 10; f++) begin
      d = '0;
      for (int k = 0; k < 8; k++) d[8*k +: 8] = 8'((f * 37 + k * 29 + 5) ^ (f << 6));
      s_frame(ADDR, 8'(f * 13), 8'(255 - f * 7), d, 8, 1'b1, acks);
      exp_cfg = d[63:0];
      chk("R3 acks full frame", 64'(acks), 64'd11);
      chk("R4 data bytes stored", cfg_regs, exp_cfg);
      chk("R9 reserved bits", {62'd0, cfg_regs[7:6]}, {62'd0, exp_cfg[7:6]});
      chk_ctl("R8 control mapping");
    end

    // R2 every single-bit corruption of the address, plus the read-direction value
    for (int b = 0; b < 9; b++) begin
      logic [7:0] bad;
      bad = (b < 8) ? (ADDR ^ 8'(1 << b)) : 8'hD3;
      d = {32'h0, 64'hA5A5_5A5A_0F0F_F0F0};
      s_frame(bad, 8'h00, 8'h08, d, 8, 1'b1, acks);
      chk("R2 no ack on wrong address", 64'(acks), 64'd0);
      chk("R2 no register change", cfg_regs, exp_cfg);
    end

    // R5 bytes beyond data byte 7 acked, discarded
    d = {32'hDEAD_BEEF, 64'h1122_3344_5566_7788};
    s_frame(ADDR, 8'h11, 8'h22, d, 12, 1'b1, acks);
    exp_cfg = d[63:0];
    chk("R5 extra bytes acked", 64'(acks), 64'd15);
    chk("R5 extra bytes discarded", cfg_regs, exp_cfg);

    // R7 truncated frame keeps committed bytes only
    d = {72'h0, 24'hC3_B2_A1};
    s_frame(ADDR, 8'h00, 8'h00, d, 3, 1'b1, acks);
    exp_cfg[23:0] = 24'hC3_B2_A1;
    chk("R7 truncated frame acks", 64'(acks), 64'd6);
    chk("R7 truncated frame commit", cfg_regs, exp_cfg);

    // R6 repeated start mid-byte restarts framing
    d = {80'h0, 16'h6E_4D};
    s_frame(ADDR, 8'h00, 8'h00, d, 2, 1'b0, acks);
    s_bits(8'hFF, 4);
    d = {88'h0, 8'h39};
    s_frame(ADDR, 8'h77, 8'h01, d, 1, 1'b1, acks);
    exp_cfg[7:0]  = 8'h39;
    exp_cfg[15:8] = 8'h6E;
    chk("R6 repeated start acks", 64'(acks), 64'd4);
    chk("R6 repeated start realign", cfg_regs, exp_cfg);
    chk_ctl("R6/R8 controls after restart");

    // R8 three-state and hold-low corners
    d = {32'h0, 64'h0000_0000_0000_3F20};
    s_frame(ADDR, 8'h00, 8'h00, d, 8, 1'b1, acks);
    exp_cfg = d[63:0];
    chk("R8 tristate all", {56'd0, clk_oe}, 64'd0);
    chk("R8 hold-low pattern", {56'd0, clk_run}, 64'h3F);
    chk_ctl("R8 corner controls");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule